// File: doc/BRIEF.md
# Interleaved Predicate Mask Scoreboard

This block holds one 64-bit integer register that serves as the predicate mask for vector operations. It also tracks which parts of that register are ready to be read. A vector compare issued with vector length VL marks every element below VL as outstanding. The compare elements then write their one-bit results one at a time. A masked element that needs predicate bit i asks the query port. The port answers ready as soon as the subregister holding bit i has no outstanding elements, so the masked element can start without waiting for the whole compare. This lets a masked operation chain behind the compare that produces its mask.

The bits are dealt out across `SUBS` interleaved subregisters (8 by default, 16 as a build option). Bit i lives in subregister i mod `SUBS`. Readiness is tracked per subregister, which keeps the number of tracked entries small for the scheduler. Scalar compares and record-form operations never reach this block. A new compare is refused while an earlier one still has outstanding elements.

Top module: `pmask_sb`

## Requirements
- R1: After synchronous active-high reset, all mask bits are 0, no element is outstanding and `cmp_busy_o` is 0. A query issued in the first cycle after reset reports ready with bit value 0.
- R2: A compare issue while `cmp_busy_o` is 0 is accepted. On the next cycle every element with index below `cmp_vl_i` is outstanding, and `cmp_busy_o` is 1 if `cmp_vl_i` is nonzero. A `cmp_vl_i` above 64 covers all 64 elements.
- R3: Element i belongs to subregister i mod `SUBS`, which is the low log2(`SUBS`) bits of the index. A query for element i reports ready exactly when no outstanding element j satisfies j mod `SUBS` = i mod `SUBS`.
- R4: A result write to an outstanding element stores `res_bit_i` at bit `res_idx_i` and clears that element's outstanding state. A subregister becomes ready once all of its elements are written, whatever the state of the other subregisters.
- R5: An accepted issue clears every mask bit to 0. Bits at or above VL stay 0 and their queries report ready with value 0.
- R6: A compare issue while `cmp_busy_o` is 1 is refused. It neither changes the mask nor adds outstanding elements.
- R7: A result write to an element that is not outstanding has no effect. This covers an index at or above VL, an element already written, and a write while idle, including a write in the same cycle as an accepted issue.
- R8: The query outputs are registered. `qry_ready_o` and `qry_bit_o` reflect the state before the clock edge that samples `qry_idx_i`, so a query in the same cycle as the write that completes its subregister still reports not ready. `qry_bit_o` is meaningful only when `qry_ready_o` is 1.
- R9: `cmp_busy_o` is 1 exactly when some element is outstanding. It falls in the cycle after the last outstanding write, and a new issue is accepted from then on.
- R10: An issue with `cmp_vl_i` = 0 is accepted. It clears the mask and leaves `cmp_busy_o` at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmp_issue_i | input | 1 | Vector compare issue request |
| cmp_vl_i | input | 7 | Vector length of the compare |
| cmp_busy_o | output | 1 | Some element outstanding; issue is refused |
| res_valid_i | input | 1 | Compare element result write strobe |
| res_idx_i | input | 6 | Element index of the result |
| res_bit_i | input | 1 | Result bit value |
| qry_idx_i | input | 6 | Element index queried by a masked operation |
| qry_ready_o | output | 1 | Registered: queried subregister is not pending |
| qry_bit_o | output | 1 | Registered: queried mask bit value |

## Verification
Two collisions are provoked on purpose. The first is a result write and a query of the same subregister in the same cycle. It is judged by expecting not ready in that cycle and ready with the written bit on the next cycle. The second is a compare issue together with a result write. When the block is idle, the write must be dropped. When a compare is still outstanding, the issue must be dropped and the write kept. A long random phase mixes both collisions with all VL values, and the bench compares every output on every clock against a behavioural model.

// File: rtl/pmask_sb_pkg.sv
package pmask_sb_pkg;
  localparam int unsigned DEF_MASK_W = 64;
  localparam int unsigned DEF_SUBS   = 8;

  // Number of mask bits owned by one interleaved subregister.
  function automatic int unsigned span_of(input int unsigned mask_w, input int unsigned subs);
    return mask_w / subs;
  endfunction
endpackage

// File: rtl/pmask_store.sv
module pmask_store #(
  parameter int unsigned MASK_W = 64,
  parameter int unsigned VL_W   = 7,
  parameter int unsigned IDX_W  = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              issue_acc,
  input  logic [VL_W-1:0]   vl,
  input  logic              wr_valid,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic              wr_bit,
  output logic [MASK_W-1:0] mask_q,
  output logic [MASK_W-1:0] outst_q
);
  logic wr_hit;
  assign wr_hit = wr_valid && outst_q[wr_idx];

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q  <= '0;
      outst_q <= '0;
    end else if (issue_acc) begin
      mask_q <= '0;
      for (int i = 0; i < int'(MASK_W); i++) begin
        outst_q[i] <= (VL_W'(i) < vl);
      end
    end else if (wr_hit) begin
      mask_q[wr_idx]  <= wr_bit;
      outst_q[wr_idx] <= 1'b0;
    end
  end

  AST_ISSUE_CLEARS_MASK: assert property (@(posedge clk) disable iff (rst)
    issue_acc |=> mask_q == '0); // R5

  AST_WRITE_STICKS: assert property (@(posedge clk) disable iff (rst)
    (!issue_acc && wr_hit) |=> (mask_q[$past(wr_idx)] == $past(wr_bit)) && !outst_q[$past(wr_idx)]); // R4

  AST_NO_STRAY_WRITE: assert property (@(posedge clk) disable iff (rst)
    (!issue_acc && !wr_hit) |=> $stable(mask_q) && $stable(outst_q)); // R7
endmodule

// File: rtl/pmask_group.sv
module pmask_group #(
  parameter int unsigned MASK_W = 64,
  parameter int unsigned SUBS   = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [MASK_W-1:0] outst,
  output logic [SUBS-1:0]   pending
);
  localparam int unsigned SPAN = pmask_sb_pkg::span_of(MASK_W, SUBS);

  for (genvar k = 0; k < int'(SUBS); k++) begin : g_sub
    logic [SPAN-1:0] members;
    for (genvar j = 0; j < int'(SPAN); j++) begin : g_mem
      assign members[j] = outst[k + j * SUBS];
    end
    assign pending[k] = |members;
  end

  AST_PENDING_MATCHES: assert property (@(posedge clk) disable iff (rst)
    (|pending) == (|outst)); // R9
endmodule

// File: rtl/pmask_query.sv
module pmask_query #(
  parameter int unsigned MASK_W = 64,
  parameter int unsigned SUBS   = 8,
  parameter int unsigned IDX_W  = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [MASK_W-1:0] mask,
  input  logic [SUBS-1:0]   pending,
  input  logic [IDX_W-1:0]  qry_idx,
  output logic              qry_ready,
  output logic              qry_bit
);
  localparam int unsigned SUB_W = (SUBS > 1) ? $clog2(SUBS) : 1;

  logic [SUB_W-1:0] sub_sel;
  assign sub_sel = qry_idx[SUB_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      qry_ready <= 1'b1;
      qry_bit   <= 1'b0;
    end else begin
      qry_ready <= !pending[sub_sel];
      qry_bit   <= mask[qry_idx];
    end
  end

  AST_READY_NOT_EARLY: assert property (@(posedge clk) disable iff (rst)
    (pending == '1) |=> !qry_ready); // R8
endmodule

// File: rtl/pmask_sb.sv
module pmask_sb #(
  parameter int unsigned MASK_W = pmask_sb_pkg::DEF_MASK_W,
  parameter int unsigned SUBS   = pmask_sb_pkg::DEF_SUBS,
  parameter int unsigned VL_W   = $clog2(MASK_W + 1),
  parameter int unsigned IDX_W  = $clog2(MASK_W)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmp_issue_i,
  input  logic [VL_W-1:0]  cmp_vl_i,
  output logic             cmp_busy_o,
  input  logic             res_valid_i,
  input  logic [IDX_W-1:0] res_idx_i,
  input  logic             res_bit_i,
  input  logic [IDX_W-1:0] qry_idx_i,
  output logic             qry_ready_o,
  output logic             qry_bit_o
);
  logic [MASK_W-1:0] mask;
  logic [MASK_W-1:0] outst;
  logic [SUBS-1:0]   pending;
  logic              issue_acc;

  assign cmp_busy_o = |pending;
  assign issue_acc  = cmp_issue_i && !cmp_busy_o;

  pmask_store #(.MASK_W(MASK_W), .VL_W(VL_W), .IDX_W(IDX_W)) u_store (
    .clk(clk), .rst(rst), .issue_acc(issue_acc), .vl(cmp_vl_i),
    .wr_valid(res_valid_i), .wr_idx(res_idx_i), .wr_bit(res_bit_i),
    .mask_q(mask), .outst_q(outst)
  );

  pmask_group #(.MASK_W(MASK_W), .SUBS(SUBS)) u_group (
    .clk(clk), .rst(rst), .outst(outst), .pending(pending)
  );

  pmask_query #(.MASK_W(MASK_W), .SUBS(SUBS), .IDX_W(IDX_W)) u_query (
    .clk(clk), .rst(rst), .mask(mask), .pending(pending),
    .qry_idx(qry_idx_i), .qry_ready(qry_ready_o), .qry_bit(qry_bit_o)
  );

  AST_REFUSE_WHEN_BUSY: assert property (@(posedge clk) disable iff (rst)
    (cmp_issue_i && cmp_busy_o) |=> ((outst & ~$past(outst)) == '0)); // R6

  AST_IDLE_NOT_BUSY: assert property (@(posedge clk) disable iff (rst)
    (issue_acc && cmp_vl_i == '0) |=> !cmp_busy_o); // R10
endmodule

// File: tb/pmask_sb_bench.sv
`timescale 1ns/1ps
module pmask_sb_bench;
  localparam int S = 8;

  logic       clk = 1'b0;
  logic       rst;
  logic       cmp_issue_i;
  logic [6:0] cmp_vl_i;
  logic       cmp_busy_o;
  logic       res_valid_i;
  logic [5:0] res_idx_i;
  logic       res_bit_i;
  logic [5:0] qry_idx_i;
  logic       qry_ready_o;
  logic       qry_bit_o;

  int  checks = 0;
  int  errors = 0;
  bit  done   = 0;

  logic [63:0] m_mask;
  logic [63:0] m_out;

  always #2.5 clk = ~clk;

  pmask_sb u_pmask_sb (
    .clk(clk), .rst(rst), .cmp_issue_i(cmp_issue_i), .cmp_vl_i(cmp_vl_i),
    .cmp_busy_o(cmp_busy_o), .res_valid_i(res_valid_i), .res_idx_i(res_idx_i),
    .res_bit_i(res_bit_i), .qry_idx_i(qry_idx_i), .qry_ready_o(qry_ready_o),
    .qry_bit_o(qry_bit_o)
  );

  task automatic chk(input string tag, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %b expected %b at %0t", tag, what, act, exp, $time);
    end
  endtask

  function automatic logic model_ready(input int q);
    for (int j = 0; j < 64; j++) begin
      if ((j % S) == (q % S) && m_out[j]) return 1'b0;
    end
    return 1'b1;
  endfunction

  task automatic step(input logic iss, input int vl, input logic wv, input int wi,
                      input logic wb, input int qi, input string tag);
    logic e_rdy, e_bit, e_busy;
    @(negedge clk);
    cmp_issue_i = iss;   cmp_vl_i  = 7'(vl);
    res_valid_i = wv;    res_idx_i = 6'(wi); res_bit_i = wb;
    qry_idx_i   = 6'(qi);
    e_rdy = model_ready(qi);
    e_bit = m_mask[qi];
    if (iss && m_out == '0) begin
      m_mask = '0;
      for (int j = 0; j < 64; j++) m_out[j] = (j < vl);
    end else if (wv && m_out[wi]) begin
      m_mask[wi] = wb;
      m_out[wi]  = 1'b0;
    end
    e_busy = |m_out;
    @(posedge clk); #1;
    chk(tag, "qry_ready", qry_ready_o, e_rdy);
    if (e_rdy) chk(tag, "qry_bit", qry_bit_o, e_bit);
    chk(tag, "busy", cmp_busy_o, e_busy);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog: actual hung expected completion");
    finish_run();
  end

  initial begin
    rst = 1'b1; cmp_issue_i = 0; cmp_vl_i = 0; res_valid_i = 0;
    res_idx_i = 0; res_bit_i = 0; qry_idx_i = 0;
    m_mask = '0; m_out = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    // R1: idle state after reset
    step(0, 0, 0, 0, 0, 5, "R1");
    chk("R1", "bit after reset", qry_bit_o, 1'b0);

    // R2: issue VL=12, subregisters 0..7 get pending members
    step(1, 12, 0, 0, 0, 3, "R2");
    step(0, 0, 0, 0, 0, 3, "R2");
    chk("R2", "busy after issue", cmp_busy_o, 1'b1);
    // R3: element 11 shares subregister 3 with element 3
    step(0, 0, 1, 3, 1, 3, "R8");      // write and query same cycle
    step(0, 0, 0, 0, 0, 3, "R3");      // 11 still outstanding
    chk("R3", "sub3 waits for 11", qry_ready_o, 1'b0);
    // R6: issue while busy refused
    step(1, 64, 0, 0, 0, 40, "R6");
    // R7: write at/above VL ignored, write of done element ignored
    step(0, 0, 1, 20, 1, 20, "R7");
    step(0, 0, 1, 3, 0, 3, "R7");
    // R4: finish subregister 3 and see it ready while others pend
    step(0, 0, 1, 11, 1, 11, "R4");
    step(0, 0, 0, 0, 0, 11, "R4");
    chk("R4", "sub3 ready", qry_ready_o, 1'b1);
    chk("R4", "bit11", qry_bit_o, 1'b1);
    step(0, 0, 0, 0, 0, 19, "R4");
    chk("R4", "bit19 above VL", qry_bit_o, 1'b0);
    // R9: drain remaining elements
    for (int e = 0; e < 12; e++) step(0, 0, 1, e, e[0], e, "R9");
    step(0, 0, 0, 0, 0, 8, "R9");
    chk("R9", "busy fell", cmp_busy_o, 1'b0);
    // R5: new issue clears bits; element above VL ready and zero
    step(1, 4, 0, 0, 0, 11, "R5");
    step(0, 0, 0, 0, 0, 11, "R5");
    chk("R5", "bit11 cleared", qry_bit_o, 1'b0);
    step(0, 0, 0, 0, 0, 6, "R5");
    chk("R5", "sub6 ready", qry_ready_o, 1'b1);
    for (int e = 0; e < 4; e++) step(0, 0, 1, e, 1'b1, e, "R9");
    // R10: VL=0 with simultaneous write while idle (R7)
    step(1, 0, 1, 0, 1, 0, "R10");
    step(0, 0, 0, 0, 0, 0, "R10");
    chk("R10", "not busy", cmp_busy_o, 1'b0);
    chk("R10", "bit0 cleared", qry_bit_o, 1'b0);
    // R2: full length and beyond
    step(1, 70, 0, 0, 0, 63, "R2");
    for (int e = 63; e >= 0; e--) step(0, 0, 1, e, e[1], 63 - e, "R4");
    // random mix, model compared every clock
    for (int n = 0; n < 3000; n++) begin
      logic iss, wv, wb;
      int vl, wi, qi;
      iss = ($urandom % 6) == 0;
      vl  = $urandom % 70;
      wv  = ($urandom % 4) != 0;
      wi  = (($urandom % 3) == 0) ? ($urandom % 64) : ($urandom % 20);
      wb  = $urandom % 2;
      qi  = (($urandom % 2) == 0) ? wi : ($urandom % 64);
      step(iss, vl, wv, wi, wb, qi, "R3");
    end
    finish_run();
  end
endmodule